// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A request brings the virtual address, the kind of access (instruction fetch, data load or data store), the effective privilege, the root table page number, a flag saying whether paged translation is on, and the two status bits that widen supervisor access to user pages (`sum`) and let executable pages be read (`mxr`). The walker reads page table entries through a simple memory port that completes each read or write when the memory raises `mem_ack`. It answers with a single-cycle response: a physical address plus read, write and execute permission, or a page fault that echoes the access kind so that the trap logic can pick the matching cause.

Machine-privilege requests and requests with translation off are answered at once without touching memory. Otherwise each level's entry is checked: a valid entry with no permission bits points to the next table, and any other valid entry is a leaf that must pass the full set of validity, privilege, alignment and access rules. A leaf that passes gets its accessed bit (and, for stores, its dirty bit) set. The entry goes back to memory only when one of those bits was clear. A leaf at the first level maps a 4 MiB superpage.

Top module: `vm_walker`

## Requirements
- R1: A request with `req_priv` = 3 (machine) or `req_paged` = 0 returns `rsp_paddr` equal to the zero-extended virtual address, with read, write and execute all granted and no fault. It makes no memory access.
- R2: The first entry is read at `root_ppn`*4096 + VA[31:22]*4. After a pointer entry (V=1, R=W=X=0; entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, page number in 31:10), the second entry is read at entry_ppn*4096 + VA[21:12]*4. A second-level leaf maps to {entry_ppn, VA[11:0]}.
- R3: An entry with V clear ends the walk with a fault.
- R4: A leaf with W set and R clear is reserved and faults. This covers both W alone and W with X.
- R5: Privilege codes are 0 for user and 1 for supervisor. A leaf with U set faults when the privilege is not user and `sum` is 0, and it always faults for a fetch at a privilege other than user. A leaf with U clear faults when the privilege is user.
- R6: A first-level leaf whose entry page number has any of its low 10 bits set faults. An aligned first-level leaf maps to {entry_ppn[21:10], VA[21:0]}.
- R7: Access codes are 0 for fetch, 1 for load and 2 for store. A load needs R, or X with `mxr` set. A store needs W. A fetch needs X.
- R8: On success the entry is written back to the address it was read from, with A set, and with D also set for a store. The write happens only if this changes the entry. Reads and writes never overlap.
- R9: A successful response grants read when R is set, or when X and `mxr` are both set. It grants execute when X is set. It grants write when W is set and the access is a store or D was already set.
- R10: A pointer entry found at the second level ends the walk with a fault.
- R11: Every response carries the request's access code in `rsp_acc`. A fault response has a zero address and no permissions, and no entry is written during a walk that ends in a fault.
- R12: `req_ready` is high only when no walk is in progress. No memory access or response happens then. `rsp_valid` lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| req_paged | input | 1 | Paged translation enabled |
| root_ppn | input | 22 | Root table page number |
| sum | input | 1 | Supervisor may access user pages |
| mxr | input | 1 | Executable pages are readable |
| mem_rd | output | 1 | Entry read request, held until acknowledged |
| mem_wr | output | 1 | Entry write-back request, held until acknowledged |
| mem_addr | output | 34 | Entry byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Memory completes the current read or write |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permission |
| rsp_w | output | 1 | Write permission |
| rsp_x | output | 1 | Execute permission |
| rsp_acc | output | 2 | Access kind of the answered request |

## Verification
A wrong level counter or base register shows up as a wrong `mem_addr` on the second read, one cycle after the first entry is acknowledged. A wrong check result shows up on `rsp_fault` or the permission bits in the response strobe, two cycles after the entry arrives. A latched entry that is not updated correctly shows up as a missing or wrong write-back before the response. The sweep covers every combination of the low eight entry bits, against every access kind, privilege, `sum` and `mxr` setting. This makes a single swapped condition in the leaf rules visible within one walk of a few cycles.

// File: rtl/walk_pkg.sv
// Shared encodings for the page table walker: access kinds, privilege
// codes, entry bit positions and the walk state type.
package walk_pkg;
    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;
    localparam int PTE_PPN_LSB = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/walk_leaf_check.sv
// Entry classifier. Decides whether an entry is invalid, a pointer, or a
// leaf, and whether that leaf is legal for the access. It also gives the
// updated entry and the granted permissions.
// Assumes the entry page number starts at bit PTE_PPN_LSB and that
// level 0 is the last level.
module walk_leaf_check
    import walk_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int IDX_W = 10,
    parameter int LVL_W = 1
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] lvl,
    input  logic [1:0]       acc,
    input  logic [1:0]       priv,
    input  logic             sum,
    input  logic             mxr,
    output logic             invalid,
    output logic             is_ptr,
    output logic             leaf_fault,
    output logic             need_wr,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x,
    output logic [PTE_W-1:0] pte_upd
);
    localparam int PPN_W = PTE_W - PTE_PPN_LSB;

    logic             f_r, f_w, f_x, f_u, f_d;
    logic [PPN_W-1:0] ppn, span_mask;
    logic             rsvd, user_bad, misal, acc_bad;

    // Field extraction
    assign f_r = pte[B_R];
    assign f_w = pte[B_W];
    assign f_x = pte[B_X];
    assign f_u = pte[B_U];
    assign f_d = pte[B_D];
    assign ppn = pte[PTE_W-1:PTE_PPN_LSB];
    assign span_mask = ~({PPN_W{1'b1}} << (IDX_W * int'(lvl)));

    assign invalid = ~pte[B_V];
    assign is_ptr  = pte[B_V] & ~(f_r | f_w | f_x);

    // Leaf legality ladder
    always_comb begin
        rsvd = f_w & ~f_r;
        if (f_u)
            user_bad = (priv != PRIV_U) && (!sum || acc == ACC_FETCH);
        else
            user_bad = (priv == PRIV_U);
        misal = |(ppn & span_mask);
        case (acc)
            ACC_LOAD:  acc_bad = ~(f_r | (f_x & mxr));
            ACC_STORE: acc_bad = ~f_w;
            default:   acc_bad = ~f_x;
        endcase
        leaf_fault = rsvd | user_bad | misal | acc_bad;
    end

    // Accessed/dirty update and granted permissions
    always_comb begin
        pte_upd = pte;
        pte_upd[B_A] = 1'b1;
        if (acc == ACC_STORE) pte_upd[B_D] = 1'b1;
        need_wr = (pte_upd != pte);
        perm_r  = f_r | (f_x & mxr);
        perm_x  = f_x;
        perm_w  = f_w & ((acc == ACC_STORE) | f_d);
    end
endmodule

// File: rtl/walk_addr_gen.sv
// Address former. Builds the byte address of the entry for the current
// level from the table base, and composes the physical address of a leaf,
// filling superpage spans from the virtual page number.
// Assumes page-aligned tables and level 0 as the last level.
module walk_addr_gen #(
    parameter int VA_W      = 32,
    parameter int PPN_W     = 22,
    parameter int PG_SHIFT  = 12,
    parameter int IDX_W     = 10,
    parameter int LVL_W     = 1,
    parameter int PTE_BYTES = 4
) (
    input  logic [VA_W-1:0]           vaddr,
    input  logic [LVL_W-1:0]          lvl,
    input  logic [PPN_W-1:0]          base_ppn,
    input  logic [PPN_W-1:0]          leaf_ppn,
    output logic [PPN_W+PG_SHIFT-1:0] pte_addr,
    output logic [PPN_W+PG_SHIFT-1:0] leaf_paddr
);
    localparam int PA_W   = PPN_W + PG_SHIFT;
    localparam int ENT_SH = $clog2(PTE_BYTES);

    logic [IDX_W-1:0] idx;
    logic [PPN_W-1:0] vpn_ext, span_mask;

    // Index slice for the current level
    assign idx = vaddr[PG_SHIFT + IDX_W * int'(lvl) +: IDX_W];

    // Entry address: table base plus scaled index
    assign pte_addr = {base_ppn, {PG_SHIFT{1'b0}}} + (PA_W'(idx) << ENT_SH);

    // Leaf address with superpage span taken from the virtual page number
    assign vpn_ext    = PPN_W'(vaddr[VA_W-1:PG_SHIFT]);
    assign span_mask  = ~({PPN_W{1'b1}} << (IDX_W * int'(lvl)));
    assign leaf_paddr = {(leaf_ppn & ~span_mask) | (vpn_ext & span_mask),
                         vaddr[PG_SHIFT-1:0]};
endmodule

// File: rtl/vm_walker.sv
// Page table walker top. Accepts one request at a time. It either bypasses
// translation or reads one entry per level, checks the leaf, writes back
// the accessed/dirty bits when needed, and gives a one-cycle response.
// Assumes memory holds mem_rd / mem_wr requests until mem_ack.
module vm_walker
    import walk_pkg::*;
#(
    parameter int PG_SHIFT  = 12,
    parameter int IDX_W     = 10,
    parameter int LEVELS    = 2,
    parameter int PPN_W     = 22,
    parameter int PTE_BYTES = 4,
    localparam int VA_W  = PG_SHIFT + LEVELS * IDX_W,
    localparam int PA_W  = PPN_W + PG_SHIFT,
    localparam int PTE_W = PTE_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_priv,
    input  logic             req_paged,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             sum,
    input  logic             mxr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_r,
    output logic             rsp_w,
    output logic             rsp_x,
    output logic [1:0]       rsp_acc
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    walk_state_e      state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PPN_W-1:0] base_q;
    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       acc_q, priv_q;
    logic             sum_q, mxr_q;
    logic [PTE_W-1:0] pte_q;
    logic             fault_q, r_q, w_q, x_q;
    logic [PA_W-1:0]  paddr_q;

    logic             e_invalid, e_ptr, e_leaf_fault, e_need_wr;
    logic             e_r, e_w, e_x, walk_fault;
    logic [PTE_W-1:0] e_upd;
    logic [PA_W-1:0]  ent_addr, leaf_pa;

    walk_leaf_check #(.PTE_W(PTE_W), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_check (
        .pte(pte_q), .lvl(lvl_q), .acc(acc_q), .priv(priv_q),
        .sum(sum_q), .mxr(mxr_q),
        .invalid(e_invalid), .is_ptr(e_ptr), .leaf_fault(e_leaf_fault),
        .need_wr(e_need_wr), .perm_r(e_r), .perm_w(e_w), .perm_x(e_x),
        .pte_upd(e_upd)
    );

    walk_addr_gen #(
        .VA_W(VA_W), .PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LVL_W(LVL_W), .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .vaddr(vaddr_q), .lvl(lvl_q), .base_ppn(base_q),
        .leaf_ppn(pte_q[PTE_W-1:PTE_PPN_LSB]),
        .pte_addr(ent_addr), .leaf_paddr(leaf_pa)
    );

    // Walk ends in a fault: invalid entry, pointer at last level, bad leaf
    assign walk_fault = e_invalid | (e_ptr & (lvl_q == '0))
                      | (~e_ptr & e_leaf_fault);

    // Port drive from state
    assign req_ready = (state_q == ST_IDLE);
    assign mem_rd    = (state_q == ST_READ);
    assign mem_wr    = (state_q == ST_WRITE);
    assign mem_addr  = ent_addr;
    assign mem_wdata = pte_q;
    assign rsp_valid = (state_q == ST_DONE);
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;
    assign rsp_r     = r_q;
    assign rsp_w     = w_q;
    assign rsp_x     = x_q;
    assign rsp_acc   = acc_q;

    // Walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            acc_q   <= '0;
            priv_q  <= '0;
            sum_q   <= 1'b0;
            mxr_q   <= 1'b0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            paddr_q <= '0;
            r_q     <= 1'b0;
            w_q     <= 1'b0;
            x_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    acc_q   <= req_acc;
                    priv_q  <= req_priv;
                    sum_q   <= sum;
                    mxr_q   <= mxr;
                    lvl_q   <= LVL_W'(LEVELS - 1);
                    base_q  <= root_ppn;
                    if (req_priv == PRIV_M || !req_paged) begin
                        fault_q <= 1'b0;
                        paddr_q <= PA_W'(req_vaddr);
                        r_q     <= 1'b1;
                        w_q     <= 1'b1;
                        x_q     <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    pte_q   <= mem_rdata;
                    state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (walk_fault) begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                        r_q     <= 1'b0;
                        w_q     <= 1'b0;
                        x_q     <= 1'b0;
                        state_q <= ST_DONE;
                    end else if (e_ptr) begin
                        base_q  <= pte_q[PTE_W-1:PTE_PPN_LSB];
                        lvl_q   <= lvl_q - LVL_W'(1);
                        state_q <= ST_READ;
                    end else begin
                        fault_q <= 1'b0;
                        paddr_q <= leaf_pa;
                        r_q     <= e_r;
                        w_q     <= e_w;
                        x_q     <= e_x;
                        if (e_need_wr) begin
                            pte_q   <= e_upd;
                            state_q <= ST_WRITE;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_WRITE: if (mem_ack) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/walk_checker.sv
// Protocol and response checker for vm_walker. It keeps its own copy of
// the accepted request and whether a write-back occurred in the walk.
module walk_checker
    import walk_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 34
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [1:0]      req_acc,
    input logic [1:0]      req_priv,
    input logic            req_paged,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_r,
    input logic            rsp_w,
    input logic            rsp_x,
    input logic [1:0]      rsp_acc
);
    logic [VA_W-1:0] cap_vaddr;
    logic [1:0]      cap_acc;
    logic            cap_bypass, wrote;

    // Capture each accepted request and track write-backs in its walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vaddr  <= '0;
            cap_acc    <= '0;
            cap_bypass <= 1'b0;
            wrote      <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_vaddr  <= req_vaddr;
            cap_acc    <= req_acc;
            cap_bypass <= (req_priv == PRIV_M) || !req_paged;
            wrote      <= 1'b0;
        end else if (mem_wr) begin
            wrote <= 1'b1;
        end
    end

    AST_BYPASS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_bypass) |-> (rsp_paddr == PA_W'(cap_vaddr)) && rsp_r && rsp_w && rsp_x && !rsp_fault); // R1
    AST_BYPASS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && cap_bypass) |-> !mem_rd && !mem_wr); // R1
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !wrote && !rsp_r && !rsp_w && !rsp_x && (rsp_paddr == '0)); // R11
    AST_ACC_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_acc == cap_acc)); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd && !mem_wr && !rsp_valid); // R12
endmodule

bind vm_walker walk_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_walk_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
    .req_paged(req_paged), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x), .rsp_acc(rsp_acc)
);

// File: tb/vm_walker_bench.sv
`timescale 1ns/1ps
// Bench for vm_walker: a sparse entry memory, a sweep of all leaf flag
// combinations and of every request setting, and superpage, bypass and
// invalid-root cases. Expected results are computed here from the rules.
module vm_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        req_paged = 1'b0;
    logic [21:0] root_ppn = 22'd1;
    logic        sum = 1'b0;
    logic        mxr = 1'b0;
    logic        mem_rd, mem_wr;
    logic [33:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
    logic [33:0] rsp_paddr;
    logic [1:0]  rsp_acc;

    int total = 0;
    int bad = 0;

    localparam logic [31:0] VA       = 32'h0140_7123;
    localparam logic [33:0] L1_ADDR  = 34'h1014;
    localparam logic [33:0] L2_ADDR  = 34'h201C;
    localparam logic [21:0] LEAF_PPN = 22'h2ABCD;

    always #4 clk = ~clk;

    vm_walker u_vm_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
        .req_paged(req_paged), .root_ppn(root_ppn), .sum(sum), .mxr(mxr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x), .rsp_acc(rsp_acc)
    );

    // Entry memory model: one access acknowledged per request, at negedge
    logic [31:0] mem [0:4095];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [33:0] rd_log [0:3];
    logic [33:0] wr_addr_last = '0;
    logic [31:0] wr_data_last = '0;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_rd) begin
            mem_rdata = mem[mem_addr[13:2]];
            rd_log[rd_cnt % 4] = mem_addr;
            rd_cnt = rd_cnt + 1;
            mem_ack = 1'b1;
        end else if (mem_wr) begin
            mem[mem_addr[13:2]] = mem_wdata;
            wr_addr_last = mem_addr;
            wr_data_last = mem_wdata;
            wr_cnt = wr_cnt + 1;
            mem_ack = 1'b1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Results of the last walk
    logic        g_fault, g_r, g_w, g_x;
    logic [33:0] g_paddr;
    logic [1:0]  g_acc;
    int          n_rd, n_wr;
    logic [33:0] rd_a0, rd_a1;

    task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                        input logic [1:0] priv, input logic paged,
                        input logic s, input logic m);
        int rd0, wr0;
        bit seen;
        @(negedge clk);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        req_vaddr = va; req_acc = acc; req_priv = priv;
        req_paged = paged; sum = s; mxr = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R12", "response seen", 64'(seen), 64'd1);
        g_fault = rsp_fault; g_paddr = rsp_paddr; g_acc = rsp_acc;
        g_r = rsp_r; g_w = rsp_w; g_x = rsp_x;
        n_rd = rd_cnt - rd0;
        n_wr = wr_cnt - wr0;
        rd_a0 = rd_log[rd0 % 4];
        rd_a1 = rd_log[(rd0 + 1) % 4];
    endtask

    // Reference rules for a second-level leaf
    task automatic model_leaf(input logic [7:0] f, input logic [1:0] a,
                              input logic [1:0] p, input logic s, input logic m,
                              output bit ef, output string tag,
                              output logic [2:0] erwx, output bit ewr,
                              output logic [31:0] eupd);
        logic v, r, w, x, u, d;
        logic [31:0] pte;
        v = f[0]; r = f[1]; w = f[2]; x = f[3]; u = f[4]; d = f[7];
        pte = {LEAF_PPN, 2'b00, f};
        ef = 1; erwx = 3'b000; ewr = 0; eupd = pte;
        if (!v) tag = "R3";
        else if (!r && !w && !x) tag = "R10";
        else if (w && !r) tag = "R4";
        else if (u && p != 2'd0 && (!s || a == 2'd0)) tag = "R5";
        else if (!u && p == 2'd0) tag = "R5";
        else if (a == 2'd1 && !(r || (x && m))) tag = "R7";
        else if (a == 2'd2 && !w) tag = "R7";
        else if (a == 2'd0 && !x) tag = "R7";
        else begin
            ef = 0;
            tag = "R7";
            erwx = {r || (x && m), w && (a == 2'd2 || d), x};
            eupd = pte | 32'h40 | ((a == 2'd2) ? 32'h80 : 32'h0);
            ewr = (eupd != pte);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) rd_log[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R12", "ready after reset", 64'(req_ready), 64'd1);
        chk("R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R12", "mem idle after reset", 64'({mem_rd, mem_wr}), 64'd0);

        // Bypass: machine privilege and translation off (R1)
        for (int a = 0; a < 3; a++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] va;
                va = 32'hF00D_0ABC ^ (32'h1357_9BDF * k);
                if (k == 2) walk(va, 2'(a), 2'd1, 1'b0, 1'b0, 1'b0);
                else        walk(va, 2'(a), (k == 0) ? 2'd3 : 2'd0, k == 0, 1'b0, 1'b0);
                chk("R1", "bypass fault", 64'(g_fault), 64'd0);
                chk("R1", "bypass paddr", 64'(g_paddr), 64'({2'b00, va}));
                chk("R1", "bypass perms", 64'({g_r, g_w, g_x}), 64'd7);
                chk("R1", "bypass no read", 64'(n_rd), 64'd0);
                chk("R11", "bypass acc echo", 64'(g_acc), 64'(a));
            end
        end

        // Invalid root entry (R3)
        mem[L1_ADDR[13:2]] = 32'h0000_0C0E;
        walk(VA, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R3", "invalid root fault", 64'(g_fault), 64'd1);
        chk("R3", "invalid root single read", 64'(n_rd), 64'd1);
        chk("R11", "invalid root no write", 64'(n_wr), 64'd0);

        // Pointer to a different table page (R2)
        mem[L1_ADDR[13:2]] = {22'd3, 10'h001};
        mem[12'hC07] = {LEAF_PPN, 10'h0CF};
        walk(VA, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R2", "first read addr", 64'(rd_a0), 64'(L1_ADDR));
        chk("R2", "second read addr", 64'(rd_a1), 64'h301C);
        chk("R2", "leaf paddr", 64'(g_paddr), 64'({LEAF_PPN, 12'h123}));

        // Full sweep of second-level leaf flags (R3 R4 R5 R7 R8 R9 R10)
        for (int f = 0; f < 256; f++) begin
            for (int a = 0; a < 3; a++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int sm = 0; sm < 4; sm++) begin
                        bit ef, ewr;
                        string tag;
                        logic [2:0] erwx;
                        logic [31:0] eupd;
                        mem[L1_ADDR[13:2]] = {22'd2, 10'h001};
                        mem[L2_ADDR[13:2]] = {LEAF_PPN, 2'b00, 8'(f)};
                        model_leaf(8'(f), 2'(a), 2'(p), sm[1], sm[0],
                                   ef, tag, erwx, ewr, eupd);
                        walk(VA, 2'(a), 2'(p), 1'b1, sm[1], sm[0]);
                        chk(tag, "leaf fault", 64'(g_fault), 64'(ef));
                        chk("R2", "two reads", 64'(n_rd), 64'd2);
                        chk("R2", "second read addr", 64'(rd_a1), 64'(L2_ADDR));
                        chk("R11", "acc echo", 64'(g_acc), 64'(a));
                        if (ef) begin
                            chk("R11", "no write on fault", 64'(n_wr), 64'd0);
                        end else begin
                            chk("R2", "leaf paddr", 64'(g_paddr), 64'({LEAF_PPN, 12'h123}));
                            chk("R9", "perms rwx", 64'({g_r, g_w, g_x}), 64'(erwx));
                            chk("R8", "write count", 64'(n_wr), 64'(ewr));
                            if (ewr) begin
                                chk("R8", "write data", 64'(wr_data_last), 64'(eupd));
                                chk("R8", "write addr", 64'(wr_addr_last), 64'(L2_ADDR));
                            end
                        end
                    end
                end
            end
        end

        // Superpages: alignment and span composition (R6)
        for (int k = 0; k < 4; k++) begin
            logic [9:0] lo;
            lo = (k == 0) ? 10'h000 : (k == 1) ? 10'h001 : (k == 2) ? 10'h155 : 10'h3FF;
            for (int a = 0; a < 3; a++) begin
                mem[L1_ADDR[13:2]] = {12'hA5C, lo, 10'h0CF};
                walk(VA, 2'(a), 2'd1, 1'b1, 1'b0, 1'b0);
                chk("R6", "superpage fault", 64'(g_fault), 64'(lo != 0));
                chk("R6", "superpage single read", 64'(n_rd), 64'd1);
                if (lo == 0) begin
                    chk("R6", "superpage paddr", 64'(g_paddr), 64'({12'hA5C, VA[21:0]}));
                    chk("R8", "no write when A/D set", 64'(n_wr), 64'd0);
                end
            end
        end
        // Superpage leaf with A clear: write-back at first-level address (R8)
        mem[L1_ADDR[13:2]] = {12'h0F0, 10'h000, 10'h00B};
        walk(VA, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R6", "superpage paddr", 64'(g_paddr), 64'({12'h0F0, VA[21:0]}));
        chk("R8", "superpage write addr", 64'(wr_addr_last), 64'(L1_ADDR));
        chk("R8", "superpage write data", 64'(wr_data_last), 64'({12'h0F0, 10'h000, 10'h04B}));
        chk("R9", "superpage perms", 64'({g_r, g_w, g_x}), 64'b101);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule